// File: doc/BRIEF.md
# Wired-OR Bus Arbitration Controller with Automatic Retry

This block runs the arbitration phase of a parallel wired-OR bus on behalf of one initiator whose ID is fixed by a parameter. Software raises an enable. The block then waits until the bus has been free long enough and drives the busy line together with its own one-hot ID bit. After a programmable delay it reads the data lines. If no higher-priority ID is present, it also drives the select line and reports a win.

A loss does not end the attempt. The block drops its drives and waits for the next bus-free condition, then tries again. It keeps doing this until it wins or software clears the enable. A second mode arbitrates without placing an ID on the data lines. This mode wins only on completely empty data lines, and it reports its result on its own status flag.

Each bus line is modelled as a separate input (the resolved line state) and output (this block's drive).

Top module: `bus_arb_ctrl`

## Requirements
- R1: While reset is held, and after it until the enable is raised, `bsy_out`, `sel_out`, `data_out`, `arb_busy`, `won_norm` and `won_noid` are all low.
- R2: Arbitration starts only after `bsy_in` and `sel_in` have both been sampled low on `settle_cycles` consecutive clock edges while waiting (a value of 0 counts as 1). Any edge with either line high restarts the count.
- R3: During arbitration the block drives `bsy_out` high. In normal mode it drives `data_out` = 1 << MY_ID, and in no-ID mode it drives `data_out` = 0. It holds this for `arb_delay` clock edges (0 counts as 1) before it decides. The mode is taken from `noid_mode` on the edge that starts arbitration.
- R4: In normal mode the block wins exactly when no `data_in` bit above index MY_ID is set. Bit 7 is the highest priority and bits at or below MY_ID are ignored.
- R5: In no-ID mode the block wins exactly when all eight `data_in` bits are 0.
- R6: After a win, `bsy_out` and `sel_out` stay high and `arb_busy` is low. `won_norm` (normal mode) or `won_noid` (no-ID mode) is high. All of this holds, whatever the bus does, until the enable is cleared.
- R7: After a loss, the block releases `bsy_out` and `data_out` on the next edge while `arb_busy` stays high. It then arbitrates again by itself at the next bus-free condition.
- R8: If `sel_in` is seen high during arbitration, the block releases its drives on the next edge and goes back to waiting for bus free.
- R9: Clearing `arb_en` in any state releases all drives and clears all flags on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arb_en | input | 1 | Arbitration enable from software |
| noid_mode | input | 1 | 1 selects arbitration without an ID |
| settle_cycles | input | CNT_W | Bus-free settle count |
| arb_delay | input | CNT_W | Arbitration delay count |
| bsy_in | input | 1 | Resolved busy line |
| sel_in | input | 1 | Resolved select line |
| data_in | input | 8 | Resolved data lines |
| bsy_out | output | 1 | Busy line drive |
| sel_out | output | 1 | Select line drive |
| data_out | output | 8 | Data line drive (own ID bit) |
| arb_busy | output | 1 | Arbitration in progress |
| won_norm | output | 1 | Won in normal mode |
| won_noid | output | 1 | Won in no-ID mode |

## Verification
The bench drives a busy or select pulse one edge before the settle count would complete. A design that does not restart the count would start arbitration early. Data patterns check that IDs below its own, including all of them at once, are ignored and that any higher bit causes a loss. A priority check that is off by one or reversed would flip some of these results. In no-ID mode, a lone low ID and a bit equal to its own ID must each cause a loss. A loss followed by a held bus and then a release must end in a win, so a design that stops after losing is caught. A select pulse during the delay, and clearing the enable both mid-arbitration and after a win, must each release the drives within one edge.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  localparam int ARB_ID_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_FREE,
    ST_ARB,
    ST_WON
  } arb_state_e;

  // One-hot drive pattern for a device index
  function automatic logic [ARB_ID_W-1:0] id_onehot(input int unsigned idx);
    logic [ARB_ID_W-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/arb_cycle_timer.sv
module arb_cycle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_plus;
  logic [CNT_W:0]   eff_limit;

  assign cnt_plus  = {1'b0, cnt} + 1'b1;
  assign eff_limit = (limit == '0) ? (CNT_W+1)'(1) : {1'b0, limit};
  assign done      = step && (cnt_plus >= eff_limit);

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (restart || done) cnt <= '0;
    else if (step)            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/arb_prio_cmp.sv
module arb_prio_cmp
  import bus_arb_pkg::*;
#(
  parameter int unsigned MY_ID = 5
) (
  input  logic [ARB_ID_W-1:0] bus_data,
  input  logic                noid,
  output logic                win
);
  logic [ARB_ID_W-1:0] above;
  logic                higher_seen;

  for (genvar i = 0; i < ARB_ID_W; i++) begin : g_mask
    assign above[i] = (i > MY_ID) ? bus_data[i] : 1'b0;
  end

  assign higher_seen = |above;
  assign win = noid ? (bus_data == '0) : !higher_seen;
endmodule

// File: rtl/bus_arb_ctrl.sv
module bus_arb_ctrl
  import bus_arb_pkg::*;
#(
  parameter int unsigned MY_ID = 5,
  parameter int          CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arb_en,
  input  logic                noid_mode,
  input  logic [CNT_W-1:0]    settle_cycles,
  input  logic [CNT_W-1:0]    arb_delay,
  input  logic                bsy_in,
  input  logic                sel_in,
  input  logic [ARB_ID_W-1:0] data_in,
  output logic                bsy_out,
  output logic                sel_out,
  output logic [ARB_ID_W-1:0] data_out,
  output logic                arb_busy,
  output logic                won_norm,
  output logic                won_noid
);
  localparam logic [ARB_ID_W-1:0] OWN_BIT  = id_onehot(MY_ID);
  localparam int unsigned         WIN_CEIL = 1 << (MY_ID + 1);

  arb_state_e state, nxt;
  logic       noid_q;

  // named internal events
  logic bus_busy, tmr_done, tmr_step, tmr_restart, cmp_win;
  logic decide, win_evt, lose_evt, sel_abort;
  logic [CNT_W-1:0] tmr_limit;

  assign bus_busy  = bsy_in | sel_in;
  assign sel_abort = (state == ST_ARB) && sel_in;
  assign decide    = (state == ST_ARB) && tmr_done && !sel_in;
  assign win_evt   = decide && cmp_win;
  assign lose_evt  = decide && !cmp_win;

  assign tmr_step    = ((state == ST_WAIT_FREE) && !bus_busy) || (state == ST_ARB);
  assign tmr_restart = ((state == ST_WAIT_FREE) && bus_busy) || (state != nxt);
  assign tmr_limit   = (state == ST_ARB) ? arb_delay : settle_cycles;

  arb_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmr_restart),
    .step    (tmr_step),
    .limit   (tmr_limit),
    .done    (tmr_done)
  );

  arb_prio_cmp #(.MY_ID(MY_ID)) u_cmp (
    .bus_data (data_in),
    .noid     (noid_q),
    .win      (cmp_win)
  );

  always_comb begin
    nxt = state;
    if (!arb_en) nxt = ST_IDLE;
    else begin
      unique case (state)
        ST_IDLE:      nxt = ST_WAIT_FREE;
        ST_WAIT_FREE: if (tmr_done) nxt = ST_ARB;
        ST_ARB: begin
          if (sel_abort)     nxt = ST_WAIT_FREE;
          else if (win_evt)  nxt = ST_WON;
          else if (lose_evt) nxt = ST_WAIT_FREE;
        end
        ST_WON:       nxt = ST_WON;
        default:      nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      noid_q <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_WAIT_FREE && nxt == ST_ARB) noid_q <= noid_mode;
    end
  end

  assign bsy_out  = (state == ST_ARB) || (state == ST_WON);
  assign sel_out  = (state == ST_WON);
  assign data_out = (bsy_out && !noid_q) ? OWN_BIT : '0;
  assign arb_busy = (state == ST_WAIT_FREE) || (state == ST_ARB);
  assign won_norm = (state == ST_WON) && !noid_q;
  assign won_noid = (state == ST_WON) && noid_q;

  // R2: drive only begins after a free bus
  a_r2_free_before_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bsy_out) |-> $past(!bsy_in && !sel_in));

  // R4: normal win only when nothing above own index was seen
  a_r4_no_higher_on_win: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(won_norm) |-> (int'($past(data_in)) < WIN_CEIL));

  // R5: no-ID win needs empty data lines
  a_r5_noid_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(won_noid) |-> ($past(data_in) == '0));

  a_r6_win_holds_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (won_norm || won_noid) |-> (bsy_out && sel_out && !arb_busy));

  a_r7_lose_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (lose_evt && arb_en) |=> (!bsy_out && arb_busy));

  a_r8_sel_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_abort && arb_en) |=> (!bsy_out && arb_busy));

  a_r9_disable_release: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_en |=> (!bsy_out && !sel_out && data_out == '0 && !arb_busy && !won_norm && !won_noid));
endmodule

// File: tb/bus_arb_ctrl_tb.sv
`timescale 1ns/1ps
module bus_arb_ctrl_tb;
  localparam int S = 4;
  localparam int D = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arb_en = 1'b0, noid_mode = 1'b0;
  logic [7:0] settle_cycles = 8'(S), arb_delay = 8'(D);
  logic other_bsy = 1'b0, other_sel = 1'b0;
  logic [7:0] other_data = 8'h00;
  logic bsy_out, sel_out, arb_busy, won_norm, won_noid;
  logic [7:0] data_out;
  logic bsy_in, sel_in;
  logic [7:0] data_in;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  assign bsy_in  = bsy_out | other_bsy;
  assign sel_in  = sel_out | other_sel;
  assign data_in = data_out | other_data;

  bus_arb_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .arb_en(arb_en), .noid_mode(noid_mode),
    .settle_cycles(settle_cycles), .arb_delay(arb_delay),
    .bsy_in(bsy_in), .sel_in(sel_in), .data_in(data_in),
    .bsy_out(bsy_out), .sel_out(sel_out), .data_out(data_out),
    .arb_busy(arb_busy), .won_norm(won_norm), .won_noid(won_noid)
  );

  // {others' data, noid, expect win}; own ID is 5
  localparam logic [9:0] VEC [8] = '{
    {8'h00, 1'b0, 1'b1}, {8'h1F, 1'b0, 1'b1}, {8'h40, 1'b0, 1'b0},
    {8'h80, 1'b0, 1'b0}, {8'hDF, 1'b0, 1'b0}, {8'h00, 1'b1, 1'b1},
    {8'h01, 1'b1, 1'b0}, {8'h20, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] outs();
    return {19'd0, bsy_out, sel_out, data_out, arb_busy, won_norm, won_noid};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 in reset", outs(), 32'd0);
    rst_n = 1'b1;
    tick(2);
    chk("R1 after reset", outs(), 32'd0);

    // vector table: R3 R4 R5 R6 R7
    for (int v = 0; v < 8; v++) begin
      logic exp_win, nm;
      exp_win = VEC[v][0];
      nm = VEC[v][1];
      other_data = VEC[v][9:2];
      noid_mode = nm;
      arb_en = 1'b1;
      tick(1 + S);
      chk("R3 bsy drive", {31'd0, bsy_out}, 32'd1);
      chk("R3 id drive", {24'd0, data_out}, nm ? 32'd0 : 32'h20);
      tick(D - 1);
      chk("R3 delay not done", {31'd0, sel_out}, 32'd0);
      tick(1);
      chk("R4/R5 sel", {31'd0, sel_out}, {31'd0, exp_win});
      chk("R6 won_norm", {31'd0, won_norm}, {31'd0, exp_win && !nm});
      chk("R6 won_noid", {31'd0, won_noid}, {31'd0, exp_win && nm});
      chk("R7 busy/bsy", {30'd0, arb_busy, bsy_out}, exp_win ? 32'd1 : 32'd2);
      arb_en = 1'b0;
      tick(1);
      chk("R9 release", outs(), 32'd0);
    end
    other_data = 8'h00;
    noid_mode = 1'b0;

    // R2: busy bus blocks, glitch restarts count
    other_bsy = 1'b1;
    arb_en = 1'b1;
    tick(10);
    chk("R2 held off", {30'd0, arb_busy, bsy_out}, 32'd2);
    other_bsy = 1'b0;
    tick(S - 1);
    chk("R2 before settle", {31'd0, bsy_out}, 32'd0);
    other_sel = 1'b1;
    tick(1);
    other_sel = 1'b0;
    tick(S - 1);
    chk("R2 restart", {31'd0, bsy_out}, 32'd0);
    tick(1);
    chk("R2 settled", {31'd0, bsy_out}, 32'd1);
    arb_en = 1'b0;
    tick(1);
    chk("R9 clear in arb", outs(), 32'd0);

    // R8: select seen during the delay
    arb_en = 1'b1;
    tick(1 + S);
    other_sel = 1'b1;
    tick(1);
    chk("R8 abort", {30'd0, arb_busy, bsy_out}, 32'd2);
    other_sel = 1'b0;
    arb_en = 1'b0;
    tick(1);

    // R7: lose, bus held by winner, then retry wins
    other_data = 8'h80;
    arb_en = 1'b1;
    tick(1 + S + D);
    chk("R7 lost", {29'd0, arb_busy, bsy_out, won_norm}, 32'd4);
    other_bsy = 1'b1;
    other_data = 8'h00;
    tick(6);
    chk("R7 wait held", {31'd0, bsy_out}, 32'd0);
    other_bsy = 1'b0;
    tick(S);
    chk("R7 retry arb", {31'd0, bsy_out}, 32'd1);
    tick(D);
    chk("R7 retry won", {31'd0, won_norm}, 32'd1);

    // R6: win persists under bus activity
    other_data = 8'hFF;
    other_sel = 1'b1;
    tick(20);
    chk("R6 hold", {29'd0, bsy_out, sel_out, arb_busy}, 32'd6);
    other_data = 8'h00;
    other_sel = 1'b0;
    arb_en = 1'b0;
    tick(1);
    chk("R9 clear after win", outs(), 32'd0);

    // R2/R3 zero counts behave as one
    settle_cycles = 8'd0;
    arb_delay = 8'd0;
    arb_en = 1'b1;
    tick(2);
    chk("R2 zero settle", {31'd0, bsy_out}, 32'd1);
    tick(1);
    chk("R3 zero delay", {31'd0, won_norm}, 32'd1);
    arb_en = 1'b0;
    tick(1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule